// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block chooses the next fetch address of a 32-bit RISC pipeline that has one architectural branch delay slot. Each cycle it may receive one issued instruction. It sees that instruction's address, the control-flow kind already decoded from it, and the operands that kind needs: a signed word offset or a register value, the compare flag, and the saved exception address and status word. From these it returns the next fetch address. For link operations it also returns a link-register write, and for a return from exception it returns a status-register restore.

A taken branch or jump does not redirect fetch straight away. The unit first lets the next sequential instruction issue as the delay slot. It keeps the computed destination in a register and shows a pending indication while it waits. When the slot instruction issues, fetch moves to the kept destination. A return from exception is the one exception to this: it redirects fetch in the same cycle and restores the status word in that cycle too. Fetch, decode and exception entry belong to other blocks.

Top module: `pc_redirect_unit`

## Requirements
- R1: While reset is active and just after it, `slotPending` is 0 and neither `linkWe` nor `statusWe` is asserted.
- R2: With `issueValid`=1, no pending slot and `cfOp`=0 (no transfer), `nextPc` is `curPc`+4. With `issueValid`=0, `nextPc` equals `curPc`.
- R3: A conditional branch is taken only when its condition holds. Code 1 requires `flagIn`=1 and code 2 requires `flagIn`=0. A branch that is not taken gives `curPc`+4 and leaves `slotPending` at 0 in the next cycle.
- R4: A taken transfer (a branch that is taken, code 3 jump, or code 4 jump-and-link) gives `curPc`+4 in its own cycle and sets `slotPending` from the next cycle on. When the next instruction issues, `nextPc` is the branch's `curPc` plus `wordOffset`×4, with `wordOffset` sign-extended.
- R5: Code 5 (jump to register) and code 6 (jump-and-link to register) use `regTarget` unchanged as the destination. That destination is taken on the delay-slot issue.
- R6: Codes 4 and 6 assert `linkWe` in their own cycle, with `linkData` = `curPc`+8 and `linkIdx` = the link register parameter (9 by default).
- R7: Code 7 (return from exception) gives `nextPc` = `savedPc` in the same cycle. In that cycle it also asserts `statusWe` with `statusData` = `savedStatus`, and it sets no pending slot.
- R8: While `slotPending` is 1 and `issueValid` is 0, the pending state and the kept destination stay unchanged.
- R9: The instruction that issues while a slot is pending is the delay slot. Any control-flow code it carries is ignored: it causes no link write and no status write, and it arms no new slot. `nextPc` is the kept destination, and `slotPending` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An instruction issues this cycle |
| curPc | input | 32 | Address of the issuing instruction |
| cfOp | input | 3 | Control-flow code (0..7, see requirements) |
| wordOffset | input | 26 | Signed word offset for PC-relative transfers |
| regTarget | input | 32 | Register value for register-target jumps |
| flagIn | input | 1 | Compare flag |
| savedPc | input | 32 | Saved exception return address |
| savedStatus | input | 32 | Saved status word |
| nextPc | output | 32 | Next fetch address |
| slotPending | output | 1 | A taken transfer waits for its delay slot |
| linkWe | output | 1 | Link register write enable |
| linkIdx | output | 5 | Link register index |
| linkData | output | 32 | Link register write value |
| statusWe | output | 1 | Status register restore enable |
| statusData | output | 32 | Status value to restore |

## Verification
The results fall into two groups by timing. `nextPc`, `linkWe`/`linkData` and `statusWe`/`statusData` are combinational on the issuing instruction and are due in the same cycle. The pending flag and the deferred destination appear one clock later and reach `nextPc` only on the next issue, which may be several idle cycles away. The reference model therefore computes the expected combinational outputs from the inputs it has just applied and compares them a short time after driving, well before the next rising edge. It updates its own pending state and kept destination only at that edge. As a result, the pending flag is always compared against the state left by the previous issue.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    CF_NONE     = 3'd0,
    CF_BR_SET   = 3'd1,
    CF_BR_CLR   = 3'd2,
    CF_JUMP     = 3'd3,
    CF_JUMP_LNK = 3'd4,
    CF_JUMP_REG = 3'd5,
    CF_JREG_LNK = 3'd6,
    CF_RET_EXC  = 3'd7
  } cf_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;       // no issue: keep current address
    logic takeHeld;   // delay slot issuing: use kept destination
    logic takeSaved;  // return from exception
    logic capture;    // taken transfer: keep destination
    logic useReg;     // destination comes from register operand
    logic linkWe;
    logic statusWe;
  } pcu_strobe_t;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic [2:0]  cfOp,
  input  logic        flagIn,
  output pcu_strobe_t strb,
  output logic        slotPending
);

  cf_op_e op;
  assign op = cf_op_e'(cfOp);

  always_comb begin
    strb = '0;
    if (!issueValid) begin
      strb.hold = 1'b1;
    end else if (slotPending) begin
      strb.takeHeld = 1'b1;
    end else begin
      unique case (op)
        CF_BR_SET:   strb.capture = flagIn;
        CF_BR_CLR:   strb.capture = !flagIn;
        CF_JUMP:     strb.capture = 1'b1;
        CF_JUMP_LNK: begin
          strb.capture = 1'b1;
          strb.linkWe  = 1'b1;
        end
        CF_JUMP_REG: begin
          strb.capture = 1'b1;
          strb.useReg  = 1'b1;
        end
        CF_JREG_LNK: begin
          strb.capture = 1'b1;
          strb.useReg  = 1'b1;
          strb.linkWe  = 1'b1;
        end
        CF_RET_EXC: begin
          strb.takeSaved = 1'b1;
          strb.statusWe  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           slotPending <= 1'b0;
    else if (issueValid) slotPending <= strb.capture;
  end

  // R4: an unconditional jump outside a slot arms the delay slot
  a_r4_jump_arms: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !slotPending && (cfOp == 3'd3) |=> slotPending);

  // R9: the slot instruction always consumes the pending state
  a_r9_slot_consumed: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && slotPending |=> !slotPending);

  // R8: pending state frozen while nothing issues
  a_r8_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> $stable(slotPending));

  // R7: exception return never arms a slot
  a_r7_no_slot: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !slotPending && (cfOp == 3'd7) |=> !slotPending);

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcu_strobe_t       strb,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [OFF_W-1:0]  wordOffset,
  input  logic [ADDR_W-1:0] regTarget,
  input  logic [ADDR_W-1:0] savedPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] linkData
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] seqPc, relTarget, newTarget, heldTarget, offBytes;

  assign offBytes  = {{EXT_W{wordOffset[OFF_W-1]}}, wordOffset} << 2;
  assign seqPc     = curPc + ADDR_W'(4);
  assign relTarget = curPc + offBytes;
  assign newTarget = strb.useReg ? regTarget : relTarget;
  assign linkData  = curPc + ADDR_W'(8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldTarget <= '0;
    else if (strb.capture) heldTarget <= newTarget;
  end

  always_comb begin
    if (strb.hold)           nextPc = curPc;
    else if (strb.takeHeld)  nextPc = heldTarget;
    else if (strb.takeSaved) nextPc = savedPc;
    else                     nextPc = seqPc;
  end

  // R8: kept destination unchanged while nothing is captured
  a_r8_target_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(heldTarget));

endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 26,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [2:0]        cfOp,
  input  logic [OFF_W-1:0]  wordOffset,
  input  logic [ADDR_W-1:0] regTarget,
  input  logic              flagIn,
  input  logic [ADDR_W-1:0] savedPc,
  input  logic [ADDR_W-1:0] savedStatus,
  output logic [ADDR_W-1:0] nextPc,
  output logic              slotPending,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [ADDR_W-1:0] linkData,
  output logic              statusWe,
  output logic [ADDR_W-1:0] statusData
);

  pcu_strobe_t strb;

  pcu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .cfOp(cfOp),
    .flagIn(flagIn), .strb(strb), .slotPending(slotPending)
  );

  pcu_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .curPc(curPc),
    .wordOffset(wordOffset), .regTarget(regTarget), .savedPc(savedPc),
    .nextPc(nextPc), .linkData(linkData)
  );

  assign linkWe     = strb.linkWe;
  assign linkIdx    = IDX_W'(LINK_REG);
  assign statusWe   = strb.statusWe;
  assign statusData = savedStatus;

  // R7: status restore and PC redirect go together
  a_r7_restore_with_pc: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> (nextPc == savedPc));

  // R5: register jump then slot issue lands on the register value
  a_r5_reg_target: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !slotPending && (cfOp == 3'd5)) ##1 issueValid
      |-> (nextPc == $past(regTarget)));

  // R9: nothing is written on behalf of a delay-slot instruction
  a_r9_slot_quiet: assert property (@(posedge clk) disable iff (!rstN)
    slotPending |-> !linkWe && !statusWe);

endmodule

// File: tb/pc_redirect_unit_tb_top.sv
module pc_redirect_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] curPc = '0;
  logic [2:0]  cfOp = '0;
  logic [25:0] wordOffset = '0;
  logic [31:0] regTarget = '0;
  logic        flagIn = 1'b0;
  logic [31:0] savedPc = '0;
  logic [31:0] savedStatus = '0;
  logic [31:0] nextPc, linkData, statusData;
  logic        slotPending, linkWe, statusWe;
  logic [4:0]  linkIdx;

  int nCmp = 0;
  int nBad = 0;

  // reference state
  bit          refPending = 0;
  logic [31:0] refTarget = '0;

  always #2 clk = ~clk;

  pc_redirect_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .curPc(curPc),
    .cfOp(cfOp), .wordOffset(wordOffset), .regTarget(regTarget),
    .flagIn(flagIn), .savedPc(savedPc), .savedStatus(savedStatus),
    .nextPc(nextPc), .slotPending(slotPending), .linkWe(linkWe),
    .linkIdx(linkIdx), .linkData(linkData), .statusWe(statusWe),
    .statusData(statusData)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(bit iss, bit pend, int op, bit f);
    if (!iss) return pend ? "R8" : "R2";
    if (pend) return "R9";
    case (op)
      1, 2: return "R3";
      3:    return "R4";
      4, 6: return "R6";
      5:    return "R5";
      7:    return "R7";
      default: return "R2";
    endcase
  endfunction

  // drive one cycle, compare against the model, then advance the model
  task automatic step(bit iss, int op, logic [31:0] pc, logic [25:0] off,
                      logic [31:0] rt, bit f);
    logic [31:0] exNext, exLink, dest;
    bit exLinkWe, exStatWe, taken;
    string tag;
    @(negedge clk);
    issueValid = iss; cfOp = 3'(op); curPc = pc; wordOffset = off;
    regTarget = rt; flagIn = f;
    #1;
    tag = tagOf(iss, refPending, op, f);
    exLinkWe = 0; exStatWe = 0; taken = 0;
    exLink = pc + 32'd8;
    dest = (op == 5 || op == 6) ? rt
           : pc + 32'(signed'({{6{off[25]}}, off}) * 4);
    if (!iss) exNext = pc;
    else if (refPending) exNext = refTarget;
    else begin
      exNext = pc + 32'd4;
      case (op)
        1: taken = f;
        2: taken = !f;
        3, 4, 5, 6: taken = 1;
        7: begin exNext = savedPc; exStatWe = 1; end
        default: ;
      endcase
      exLinkWe = (op == 4 || op == 6);
    end
    chk(tag, "nextPc", nextPc, exNext);
    chk(tag, "slotPending", 32'(slotPending), 32'(refPending));
    chk(tag, "linkWe", 32'(linkWe), 32'(exLinkWe));
    chk(tag, "statusWe", 32'(statusWe), 32'(exStatWe));
    if (exLinkWe) begin
      chk("R6", "linkData", linkData, exLink);
      chk("R6", "linkIdx", 32'(linkIdx), 32'd9);
    end
    if (exStatWe) chk("R7", "statusData", statusData, savedStatus);
    @(posedge clk);
    if (iss) begin
      if (refPending) refPending = 0;
      else if (taken) begin refPending = 1; refTarget = dest; end
    end
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] pc;
    savedPc = 32'h0000_2000; savedStatus = 32'h0000_8001;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "slotPending", 32'(slotPending), 32'd0);
    chk("R1", "linkWe", 32'(linkWe), 32'd0);
    chk("R1", "statusWe", 32'(statusWe), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "slotPending", 32'(slotPending), 32'd0);

    // R2: plain instruction and idle
    step(1, 0, 32'h100, 0, 0, 0);
    step(0, 0, 32'h104, 0, 0, 0);
    // R3: not-taken branches
    step(1, 1, 32'h104, 26'd5, 0, 0);
    step(1, 2, 32'h108, 26'd5, 0, 1);
    // R3/R4: taken on flag set, positive offset, then slot
    step(1, 1, 32'h10C, 26'd16, 0, 1);
    step(1, 0, 32'h110, 0, 0, 0);
    // R3/R4: taken on flag clear, negative offset
    step(1, 2, 32'h200, 26'h3FFFFFE, 0, 0);
    step(1, 0, 32'h204, 0, 0, 0);
    // R6: jump-and-link, R8: idle cycles while pending, then slot
    step(1, 4, 32'h300, 26'd64, 0, 0);
    step(0, 0, 32'h304, 0, 0, 0);
    step(0, 0, 32'h304, 0, 0, 0);
    step(1, 0, 32'h304, 0, 0, 0);
    // R5: register jump; R9: slot carries a jump-and-link, ignored
    step(1, 5, 32'h400, 0, 32'hDEAD_BEE0, 0);
    step(1, 4, 32'h404, 26'd8, 0, 0);
    // R6: register jump-and-link; R9: slot carries exception return, ignored
    step(1, 6, 32'h500, 0, 32'h0000_7000, 0);
    step(1, 7, 32'h504, 0, 0, 0);
    // R7: exception return
    step(1, 7, 32'h7000, 0, 0, 0);
    step(1, 0, 32'h2000, 0, 0, 0);

    // mixed traffic following the predicted fetch address
    pc = 32'h1000;
    for (int i = 0; i < 400; i++) begin
      bit iss = ($urandom_range(0, 9) < 8);
      int op = $urandom_range(0, 7);
      logic [25:0] off = 26'($urandom_range(0, 255)) - 26'd128;
      savedPc = {$urandom} & 32'hFFFF_FFFC;
      savedStatus = $urandom;
      step(iss, op, pc, off, {$urandom} & 32'hFFFF_FFFC, 1'($urandom));
      pc = nextPc;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule